// File: doc/BRIEF.md
# Streaming Sobel Edge Thresholder

This block turns a raster-ordered stream of 8-bit grayscale pixels into a binary edge map of the same size. Pixels enter one per accepted transfer on a valid/ready input port. The frame height and width come from configuration inputs, and a threshold input sets how strong an edge must be. Two line stores hold the two rows above the current input row, and a 3x3 window of registers slides across them. For each window the block forms a horizontal and a vertical Sobel gradient. It adds their squares and compares that sum with the threshold. No square root is taken.

Each output transfer carries one byte, either 0x00 or 0xFF, plus a start-of-frame flag and an end-of-line flag. Pixels on the outer ring of the frame are never evaluated and are always sent as 0x00.

A three-state controller sequences each frame:
- FILL: accepts row 0 and the first pixel of row 1 with no output.
- RUN: each accepted pixel produces the output for the window centre one row and one column behind it.
- DRAIN: with input held off, the last width+1 outputs are emitted; these are all border pixels.

The transitions are:
- FILL to RUN: on acceptance of pixel (row 1, column 0).
- RUN to DRAIN: on acceptance of the last pixel of the frame.
- DRAIN to FILL: when the last output pixel is loaded.

A single output register carries the handshake, and it stalls the whole pipeline when the consumer holds ready low.

Top module: `sobel_edge`

## Requirements
- R1: The horizontal gradient is (NE − NW) + 2·(E − W) + (SE − SW) over the 3x3 neighbourhood of the output pixel, as a signed 11-bit value.
- R2: The vertical gradient is (NW + 2·N + NE) − (SW + 2·S + SE), as a signed 11-bit value.
- R3: The magnitude is the sum of the two squared gradients as an unsigned 21-bit value that never wraps (at most 2,080,800). The threshold input is 21 bits wide.
- R4: An evaluated pixel is output as 0xFF when the magnitude is strictly greater than the threshold, and as 0x00 when it is equal or smaller.
- R5: Output pixels in row 0, row rows−1, column 0 and column cols−1 are always 0x00. Exactly rows·cols outputs are produced per frame, in raster order.
- R6: out_sof is high only with the output for pixel (0,0). out_eol is high exactly with each output in column cols−1.
- R7: In FILL, cols+1 pixels are accepted without any output. Each pixel accepted afterwards emits exactly one output. After the last pixel is accepted, in_ready stays low while the final cols+1 outputs drain, and it returns high once the frame has drained.
- R8: While out_valid is high and out_ready is low, out_valid, out_pix, out_sof and out_eol hold their values. No pixel is accepted in RUN until the held output leaves.
- R9: After reset, out_valid is low and in_ready is high.
- R10: cfg_rows and cfg_cols lie in 3..1024, and frames of the same size may follow back to back. Configuration is held constant from a frame's first input pixel until its last output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rows | input | 11 | Frame height in pixels |
| cfg_cols | input | 11 | Frame width in pixels |
| cfg_thresh | input | 21 | Magnitude threshold |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel |
| in_pix | input | 8 | Grayscale input pixel |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pix | output | 8 | Edge byte, 0x00 or 0xFF |
| out_sof | output | 1 | Output is pixel (0,0) of the frame |
| out_eol | output | 1 | Output is the last pixel of its row |

## Verification
The assertions watch four things on every cycle: that a stalled output holds steady, that every output byte is one of the two codes, that framed border positions carry 0x00, and that the magnitude stays within its 21-bit bound. They also check that RUN takes no input while an output is held. Whether the gradient arithmetic, the strict comparison at an exact threshold match, the fill and drain counts, and back-to-back frames are right can only be shown by the bench's scenarios. The bench compares every output byte and flag against an independent model on step images, random images, random stalls and extreme thresholds.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
    localparam int PIX_W  = 8;
    localparam int GRAD_W = PIX_W + 3;
    localparam int ABS_W  = GRAD_W - 1;
    localparam int MAG_W  = 2 * ABS_W + 1;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } sobel_state_e;
endpackage

// File: rtl/sobel_linebuf.sv
module sobel_linebuf #(
    parameter int W      = 8,
    parameter int DEPTH  = 1024,
    parameter int NLINES = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [W-1:0]                din,
    output logic [NLINES-1:0][W-1:0]    taps
);
    // Line k holds the row k+1 above the row being written.
    for (genvar k = 0; k < NLINES; k++) begin : g_line
        logic [W-1:0] mem [DEPTH];
        logic [W-1:0] wdata;

        assign taps[k] = mem[addr];

        if (k == 0) begin : g_head
            assign wdata = din;
        end else begin : g_chain
            assign wdata = taps[k-1];
        end

        always_ff @(posedge clk) begin
            if (we) begin
                mem[addr] <= wdata;
            end
        end
    end
endmodule

// File: rtl/sobel_kernel.sv
module sobel_kernel
    import sobel_pkg::*;
(
    input  logic [2:0][2:0][PIX_W-1:0] win,     // [row][col], row 0 top, col 0 left
    input  logic [MAG_W-1:0]           thresh,
    output logic [MAG_W-1:0]           mag,
    output logic                       hit
);
    logic signed [GRAD_W-1:0] t [3][3];
    logic signed [GRAD_W-1:0] gx, gy, nx, ny;
    logic [ABS_W-1:0]         ax, ay;
    logic [2*ABS_W-1:0]       sqx, sqy;

    always_comb begin
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                t[r][c] = $signed({{(GRAD_W-PIX_W){1'b0}}, win[r][c]});
            end
        end
        gx = (t[0][2] - t[0][0]) + (t[1][2] - t[1][0]) + (t[1][2] - t[1][0])
           + (t[2][2] - t[2][0]);
        gy = (t[0][0] + t[0][1] + t[0][1] + t[0][2])
           - (t[2][0] + t[2][1] + t[2][1] + t[2][2]);
        nx = -gx;
        ny = -gy;
        ax = gx[GRAD_W-1] ? nx[ABS_W-1:0] : gx[ABS_W-1:0];
        ay = gy[GRAD_W-1] ? ny[ABS_W-1:0] : gy[ABS_W-1:0];
        sqx = {{ABS_W{1'b0}}, ax} * {{ABS_W{1'b0}}, ax};
        sqy = {{ABS_W{1'b0}}, ay} * {{ABS_W{1'b0}}, ay};
        mag = {1'b0, sqx} + {1'b0, sqy};
        hit = mag > thresh;
    end
endmodule

// File: rtl/sobel_edge.sv
module sobel_edge
    import sobel_pkg::*;
#(
    parameter int MAX_COLS = 1024,
    parameter int MAX_ROWS = 1024,
    localparam int DIM_W   = $clog2(((MAX_ROWS > MAX_COLS) ? MAX_ROWS : MAX_COLS) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIM_W-1:0]   cfg_rows,
    input  logic [DIM_W-1:0]   cfg_cols,
    input  logic [MAG_W-1:0]   cfg_thresh,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PIX_W-1:0]   in_pix,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PIX_W-1:0]   out_pix,
    output logic               out_sof,
    output logic               out_eol
);
    localparam int AW     = $clog2(MAX_COLS);
    localparam int NLINES = 2;
    localparam logic [DIM_W-1:0] ONE     = DIM_W'(1);
    localparam logic [PIX_W-1:0] PIX_ON  = '1;
    localparam logic [PIX_W-1:0] PIX_OFF = '0;
    localparam int MAG_PEAK = 2 * (4 * (2**PIX_W - 1)) * (4 * (2**PIX_W - 1));
    localparam logic [MAG_W-1:0] MAG_MAX = MAG_W'(MAG_PEAK);

    sobel_state_e state_q, state_d;
    logic [DIM_W-1:0] in_col_q, in_row_q, out_col_q, out_row_q;
    logic [DIM_W-1:0] cols_m1, rows_m1;
    logic slot, acc, emit, interior, hit;
    logic in_last_col, in_last_row, out_last_col, out_last_row;
    logic [2:0][2:0][PIX_W-1:0]    win_q, win_d;
    logic [NLINES-1:0][PIX_W-1:0]  taps;
    logic [MAG_W-1:0]              mag;
    logic                          ov_q, osof_q, oeol_q;
    logic [PIX_W-1:0]              opix_q;

    assign cols_m1      = cfg_cols - ONE;
    assign rows_m1      = cfg_rows - ONE;
    assign in_last_col  = in_col_q == cols_m1;
    assign in_last_row  = in_row_q == rows_m1;
    assign out_last_col = out_col_q == cols_m1;
    assign out_last_row = out_row_q == rows_m1;
    assign interior     = (out_row_q != '0) && !out_last_row
                       && (out_col_q != '0) && !out_last_col;
    assign slot         = !ov_q || out_ready;

    always_comb begin
        unique case (state_q)
            ST_FILL:  in_ready = 1'b1;
            ST_RUN:   in_ready = slot;
            ST_DRAIN: in_ready = 1'b0;
            default:  in_ready = 1'b0;
        endcase
    end

    assign acc  = in_valid && in_ready;
    assign emit = ((state_q == ST_RUN) && acc) || ((state_q == ST_DRAIN) && slot);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (acc && (in_row_q == ONE) && (in_col_q == '0)) state_d = ST_RUN;
            ST_RUN:   if (acc && in_last_row && in_last_col)            state_d = ST_DRAIN;
            ST_DRAIN: if (emit && out_last_row && out_last_col)         state_d = ST_FILL;
            default:  state_d = ST_FILL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // Raster position counters for input and output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_col_q  <= '0;
            in_row_q  <= '0;
            out_col_q <= '0;
            out_row_q <= '0;
        end else begin
            if (acc) begin
                if (in_last_col) begin
                    in_col_q <= '0;
                    in_row_q <= in_last_row ? '0 : in_row_q + ONE;
                end else begin
                    in_col_q <= in_col_q + ONE;
                end
            end
            if (emit) begin
                if (out_last_col) begin
                    out_col_q <= '0;
                    out_row_q <= out_last_row ? '0 : out_row_q + ONE;
                end else begin
                    out_col_q <= out_col_q + ONE;
                end
            end
        end
    end

    // Window slides left; new right column is (two rows up, one row up, incoming)
    always_comb begin
        for (int r = 0; r < 3; r++) begin
            win_d[r][0] = win_q[r][1];
            win_d[r][1] = win_q[r][2];
        end
        win_d[0][2] = taps[1];
        win_d[1][2] = taps[0];
        win_d[2][2] = in_pix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   win_q <= '0;
        else if (acc) win_q <= win_d;
    end

    sobel_linebuf #(
        .W      (PIX_W),
        .DEPTH  (MAX_COLS),
        .NLINES (NLINES)
    ) u_lines (
        .clk  (clk),
        .we   (acc),
        .addr (in_col_q[AW-1:0]),
        .din  (in_pix),
        .taps (taps)
    );

    sobel_kernel u_kernel (
        .win    (win_d),
        .thresh (cfg_thresh),
        .mag    (mag),
        .hit    (hit)
    );

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_q   <= 1'b0;
            opix_q <= PIX_OFF;
            osof_q <= 1'b0;
            oeol_q <= 1'b0;
        end else if (emit) begin
            ov_q   <= 1'b1;
            opix_q <= ((state_q == ST_RUN) && interior && hit) ? PIX_ON : PIX_OFF;
            osof_q <= (out_row_q == '0) && (out_col_q == '0);
            oeol_q <= out_last_col;
        end else if (out_ready) begin
            ov_q   <= 1'b0;
        end
    end

    assign out_valid = ov_q;
    assign out_pix   = opix_q;
    assign out_sof   = osof_q;
    assign out_eol   = oeol_q;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)
                                       && $stable(out_sof) && $stable(out_eol)))
        else $error("held output changed under stall");

    assert_no_run_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && out_valid && !out_ready) |-> (state_q == ST_FILL))
        else $error("pixel accepted in RUN while output held");

    assert_binary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_pix == PIX_OFF) || (out_pix == PIX_ON)))
        else $error("output byte is not a binary code");

    assert_border_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_sof || out_eol)) |-> (out_pix == PIX_OFF))
        else $error("border output not zero");

    assert_mag_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (mag <= MAG_MAX))
        else $error("magnitude beyond bound");
endmodule

// File: tb/sobel_edge_bench.sv
module sobel_edge_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXR = 16;
    localparam int MAXC = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] cfg_rows, cfg_cols;
    logic [20:0] cfg_thresh;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_pix = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_pix;
    logic        out_sof, out_eol;

    int checks = 0;
    int fails = 0;
    int rdy_mode = 0;       // 0 always ready, 1 random, 2 never
    int acc_cnt = 0;
    int out_cnt = 0;
    bit done = 1'b0;
    bit drv_busy = 1'b0;
    logic [10:0] exp_q [$];  // {interior, sof, eol, pix}
    string       tag_q [$];
    logic [7:0]  img [MAXR][MAXC];

    always #(CLK_PERIOD/2) clk = ~clk;

    sobel_edge u_sobel_edge (
        .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
        .cfg_thresh(cfg_thresh), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
        .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int px(int r, int c);
        return int'(img[r][c]);
    endfunction

    function automatic logic [10:0] model(int r, int c, int rows, int cols, int thr);
        bit sof = (r == 0) && (c == 0);
        bit eol = (c == cols - 1);
        bit inner = (r > 0) && (r < rows - 1) && (c > 0) && (c < cols - 1);
        int gx, gy, mag;
        logic [7:0] p = 8'h00;
        if (inner) begin
            gx = (px(r-1,c+1) - px(r-1,c-1)) + 2*(px(r,c+1) - px(r,c-1))
               + (px(r+1,c+1) - px(r+1,c-1));
            gy = (px(r-1,c-1) + 2*px(r-1,c) + px(r-1,c+1))
               - (px(r+1,c-1) + 2*px(r+1,c) + px(r+1,c+1));
            mag = gx*gx + gy*gy;
            p = (mag > thr) ? 8'hFF : 8'h00;
        end
        return {inner, sof, eol, p};
    endfunction

    // Driver: pushes the expected frame, then streams its pixels
    task automatic send_frame(int rows, int cols, int thr, string req);
        bit got;
        cfg_rows   = 11'(rows);
        cfg_cols   = 11'(cols);
        cfg_thresh = 21'(thr);
        for (int r = 0; r < rows; r++)
            for (int c = 0; c < cols; c++) begin
                exp_q.push_back(model(r, c, rows, cols, thr));
                tag_q.push_back(req);
            end
        drv_busy = 1'b1;
        @(negedge clk);
        for (int r = 0; r < rows; r++)
            for (int c = 0; c < cols; c++) begin
                in_valid = 1'b1;
                in_pix   = img[r][c];
                do begin
                    #(CLK_PERIOD/4);
                    got = in_ready;
                    if (got) acc_cnt++;
                    @(negedge clk);
                end while (!got);
            end
        in_valid = 1'b0;
        drv_busy = 1'b0;
    endtask

    // Monitor: drives ready, pops and compares accepted outputs
    always begin
        logic [10:0] e;
        string t;
        @(negedge clk);
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = ($urandom % 3) != 0;
            default: out_ready = 1'b0;
        endcase
        #(CLK_PERIOD/4);
        if (rst_n && out_valid && out_ready) begin
            out_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 extra output", 1, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e[10]) check(out_pix == e[7:0], t, int'(out_pix), int'(e[7:0]));
                else       check(out_pix == e[7:0], "R5 border", int'(out_pix), int'(e[7:0]));
                check(out_sof == e[9], "R6 sof", int'(out_sof), int'(e[9]));
                check(out_eol == e[8], "R6 eol", int'(out_eol), int'(e[8]));
            end
        end
    end

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic fill_random();
        for (int r = 0; r < MAXR; r++)
            for (int c = 0; c < MAXC; c++)
                img[r][c] = 8'($urandom);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        cfg_rows = 11'd3; cfg_cols = 11'd3; cfg_thresh = '0;
        repeat (4) @(negedge clk);
        #(CLK_PERIOD/4);
        check(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk); #(CLK_PERIOD/4);
        check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);

        // R1: vertical step, gradient 400 -> magnitude 160000 at the step
        for (int r = 0; r < MAXR; r++)
            for (int c = 0; c < MAXC; c++)
                img[r][c] = (c < 4) ? 8'd10 : 8'd110;
        rdy_mode = 0;
        send_frame(6, 8, 1000, "R1");
        wait_empty();
        // R4: exact equality gives 0, one below gives 255
        send_frame(6, 8, 160000, "R4 equal");
        wait_empty();
        send_frame(6, 8, 159999, "R4 below");
        wait_empty();

        // R2: horizontal step
        for (int r = 0; r < MAXR; r++)
            for (int c = 0; c < MAXC; c++)
                img[r][c] = (r < 3) ? 8'd200 : 8'd20;
        send_frame(7, 5, 5000, "R2");
        wait_empty();

        // R3: checkerboard of extremes against large thresholds
        for (int r = 0; r < MAXR; r++)
            for (int c = 0; c < MAXC; c++)
                img[r][c] = ((r + c) % 2 == 0) ? 8'hFF : 8'h00;
        send_frame(5, 6, 2097151, "R3 top threshold");
        wait_empty();
        send_frame(5, 6, 0, "R3 zero threshold");
        wait_empty();
        for (int r = 0; r < MAXR; r++)
            for (int c = 0; c < MAXC; c++)
                img[r][c] = (c % 3 == 2) ? 8'hFF : 8'h00;
        send_frame(5, 7, 1040399, "R3 peak");
        wait_empty();

        // R7: input held off while the frame drains, then ready again
        fill_random();
        send_frame(4, 9, 20000, "R7");
        #(CLK_PERIOD/4);
        check(in_ready == 1'b0, "R7 in_ready during drain", int'(in_ready), 0);
        wait_empty();
        #(CLK_PERIOD/4);
        check(in_ready == 1'b1, "R7 in_ready after drain", int'(in_ready), 1);

        // R8: consumer never ready -> fill plus one output, then stall
        fill_random();
        rdy_mode = 2;
        base = acc_cnt;
        fork
            send_frame(5, 10, 30000, "R8");
        join_none
        repeat (60) @(negedge clk);
        #(CLK_PERIOD/4);
        check(acc_cnt - base == 12, "R8 accepted before stall", acc_cnt - base, 12);
        check(out_valid == 1'b1, "R8 out_valid held", int'(out_valid), 1);
        check(out_sof == 1'b1, "R6 first output flagged", int'(out_sof), 1);
        @(negedge clk);
        rdy_mode = 1;
        wait (drv_busy == 1'b0);
        wait_empty();

        // R10: back-to-back frames at both size extremes under random stalls
        fill_random();
        send_frame(3, 3, 100, "R10 minimum");
        send_frame(3, 3, 100, "R10 minimum");
        wait_empty();
        base = out_cnt;
        send_frame(MAXR, MAXC, 40000, "R10 repeat");
        fill_random();
        send_frame(MAXR, MAXC, 40000, "R10 repeat");
        wait_empty();
        check(out_cnt - base == 2*MAXR*MAXC, "R5 output count", out_cnt - base, 2*MAXR*MAXC);

        // Random images and thresholds
        for (int k = 0; k < 8; k++) begin
            int rr = 3 + int'($urandom % (MAXR - 2));
            int cc = 3 + int'($urandom % (MAXC - 2));
            fill_random();
            send_frame(rr, cc, int'($urandom % 300000), "R4 random");
            wait_empty();
        end

        check(exp_q.size() == 0, "R5 queue empty", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule